// File: doc/BRIEF.md
# Channel Duration Length Counter Bank

This block times how long each of four sound-generator channels stays audible. Each channel holds a down-counter. A load write carries a 5-bit index in its data byte. A fixed, non-linear 32-entry table turns that index into a starting count. An external frame sequencer pulses a strobe, and each strobe takes one off the count. When the count reaches zero the channel's mute output rises, which silences the waveform generator behind it.

A shared enable register holds one flag per channel. A channel whose flag is clear ignores load writes and keeps its count at zero. Clearing a flag throws away whatever count was in progress. Each channel also has a halt flag that freezes the count. The halt flag arrives through the channel's control write, at a bit position shared with a neighbouring unit's control flag. Every load write also produces a one-cycle restart pulse, which the envelope, phase or reload logic uses.

Channel numbering: channel 0 is pulse 1, channel 1 is pulse 2, channel 2 is triangle, channel 3 is noise.

Top module: `len_counter_bank`

## Requirements
- R1: A load write to an enabled channel sets its count from the table entry selected by data bits 7..3, effective in the next cycle. Indexes 0..15 map to 10, 254, 20, 2, 40, 4, 80, 6, 160, 8, 60, 10, 14, 12, 26, 14. Indexes 16..31 map to 12, 16, 24, 18, 48, 20, 96, 22, 192, 24, 72, 26, 16, 28, 32, 30.
- R2: A load write to a channel whose enable flag is clear leaves the count unchanged, so it stays zero.
- R3: Each frame strobe lowers a non-zero, unhalted count by one. A count of zero stays at zero. After a load of value N, the channel is still active after N-1 strobes and silent after the Nth strobe. Without a strobe or a load, the count does not change.
- R4: The halt flag comes from a control write: data bit 5 for channels 0, 1 and 3, and bit 7 for channel 2. It takes effect from the next cycle. While the flag is set, strobes do not change the count.
- R5: An enable-register write with a channel's bit clear makes that count zero in the next cycle. Setting the bit again does not bring the old count back, and a set bit has no effect on the count by itself.
- R6: mute[i] is 1 exactly when count i is zero. active[i] is the inverse of mute[i].
- R7: restart[i] is high for exactly the one cycle after each load write to channel i, whether or not the channel is enabled.
- R8: Enable-register data bits 0..3 are the flags of channels 0..3. Bits 7..4 are ignored. Channels do not affect one another.
- R9: A synchronous active-high reset clears every count, enable flag, halt flag and restart pulse. After reset, mute is 4'hF.
- R10: When a load write and a frame strobe fall in the same cycle, the loaded value is kept and no decrement is applied.
- R11: When an enable write and a load write fall in the same cycle, the load is accepted only if the newly written flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ena_wr | input | 1 | Write the shared enable register from wr_data[3:0] |
| ctrl_wr | input | 4 | Per-channel control write, which samples the halt bit |
| load_wr | input | 4 | Per-channel load write, which takes the table index from wr_data[7:3] |
| wr_data | input | 8 | Shared write data byte |
| frame_tick | input | 1 | Decrement strobe from the frame sequencer |
| mute | output | 4 | Channel silenced (count is zero) |
| active | output | 4 | Count is non-zero |
| restart | output | 4 | One-cycle side-effect pulse after a load write |

## Verification
The hardest cases to reach are the cycles where two events land on the same edge. One is a load coinciding with a strobe. The other is a load coinciding with an enable write that turns the channel on or off. Both are easy to miss because strobes are sparse in normal use. The bench drives these collisions on purpose in single cycles. It also sweeps every table index on every channel. Each sweep runs an uninterrupted stream of strobes, and the bench checks the exact strobe on which the channel goes silent.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = 5;
    localparam int IDX_LSB = 3;
    localparam int CNT_W   = 8;
    localparam int NCH     = 4;
    localparam int TRI_CH  = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             halt;
        logic             restart;
    } ch_state_t;

    function automatic int halt_bit_of(input int ch);
        return (ch == TRI_CH) ? 7 : 5;
    endfunction
endpackage

// File: rtl/lc_len_rom.sv
module lc_len_rom
    import lc_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] len
);
    always_comb begin
        if (idx[0]) begin
            // odd entries: one less than the index, except index 1
            len = (idx == IDX_W'(1)) ? CNT_W'(254) : CNT_W'(idx - IDX_W'(1));
        end else begin
            unique case (idx[4:1])
                4'h0: len = CNT_W'(10);
                4'h1: len = CNT_W'(20);
                4'h2: len = CNT_W'(40);
                4'h3: len = CNT_W'(80);
                4'h4: len = CNT_W'(160);
                4'h5: len = CNT_W'(60);
                4'h6: len = CNT_W'(14);
                4'h7: len = CNT_W'(26);
                4'h8: len = CNT_W'(12);
                4'h9: len = CNT_W'(24);
                4'hA: len = CNT_W'(48);
                4'hB: len = CNT_W'(96);
                4'hC: len = CNT_W'(192);
                4'hD: len = CNT_W'(72);
                4'hE: len = CNT_W'(16);
                default: len = CNT_W'(32);
            endcase
        end
    end
endmodule

// File: rtl/lc_channel.sv
module lc_channel
    import lc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic             en_bit,
    input  logic             ctrl_wr,
    input  logic             halt_bit,
    input  logic             load_wr,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             frame_tick,
    output logic             active,
    output logic             mute,
    output logic             restart,
    output logic             enabled
);
    ch_state_t        st_d, st_q;
    logic [CNT_W-1:0] rom_len;
    logic             en_next;

    lc_len_rom u_rom (
        .idx (load_idx),
        .len (rom_len)
    );

    always_comb begin
        st_d         = st_q;
        en_next      = en_wr ? en_bit : st_q.en;
        st_d.en      = en_next;
        st_d.halt    = ctrl_wr ? halt_bit : st_q.halt;
        st_d.restart = load_wr;
        if (!en_next) begin
            st_d.cnt = '0;
        end else if (load_wr) begin
            st_d.cnt = rom_len;
        end else if (frame_tick && !st_q.halt && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign active  = (st_q.cnt != '0);
    assign mute    = (st_q.cnt == '0);
    assign restart = st_q.restart;
    assign enabled = st_q.en;
endmodule

// File: rtl/len_counter_bank.sv
module len_counter_bank
    import lc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ena_wr,
    input  logic [NCH-1:0]    ctrl_wr,
    input  logic [NCH-1:0]    load_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_tick,
    output logic [NCH-1:0]    mute,
    output logic [NCH-1:0]    active,
    output logic [NCH-1:0]    restart
);
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] halt_in;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int HB = halt_bit_of(i);
        assign halt_in[i] = wr_data[HB];

        lc_channel u_ch (
            .clk        (clk),
            .rst        (rst),
            .en_wr      (ena_wr),
            .en_bit     (wr_data[i]),
            .ctrl_wr    (ctrl_wr[i]),
            .halt_bit   (halt_in[i]),
            .load_wr    (load_wr[i]),
            .load_idx   (wr_data[IDX_LSB +: IDX_W]),
            .frame_tick (frame_tick),
            .active     (active[i]),
            .mute       (mute[i]),
            .restart    (restart[i]),
            .enabled    (en_q[i])
        );
    end
endmodule

// File: rtl/len_counter_bank_chk.sv
module len_counter_bank_chk
    import lc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ena_wr,
    input logic [NCH-1:0]    load_wr,
    input logic [DATA_W-1:0] wr_data,
    input logic              frame_tick,
    input logic [NCH-1:0]    active,
    input logic [NCH-1:0]    restart,
    input logic [NCH-1:0]    en_q
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (ena_wr && !wr_data[i]) |=> !active[i]);                      // R5
        AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
            load_wr[i] |=> restart[i]);                                    // R7
        AST_NO_STRAY_RESTART: assert property (@(posedge clk) disable iff (rst)
            !load_wr[i] |=> !restart[i]);                                  // R7
        AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
            (!load_wr[i] && !active[i]) |=> !active[i]);                   // R3
        AST_DISABLED_LOAD: assert property (@(posedge clk) disable iff (rst)
            (!en_q[i] && !ena_wr && load_wr[i]) |=> !active[i]);           // R2
        AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
            (en_q[i] && !ena_wr && load_wr[i]) |=> active[i]);             // R10
        AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
            (active[i] && !frame_tick && !ena_wr) |=> active[i]);          // R3
    end
endmodule

bind len_counter_bank len_counter_bank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ena_wr     (ena_wr),
    .load_wr    (load_wr),
    .wr_data    (wr_data),
    .frame_tick (frame_tick),
    .active     (active),
    .restart    (restart),
    .en_q       (en_q)
);

// File: tb/tb_len_counter_bank.sv
`timescale 1ns/1ps
module tb_len_counter_bank;
    logic       clk = 1'b0;
    logic       rst;
    logic       ena_wr;
    logic [3:0] ctrl_wr;
    logic [3:0] load_wr;
    logic [7:0] wr_data;
    logic       frame_tick;
    logic [3:0] mute;
    logic [3:0] active;
    logic [3:0] restart;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    len_counter_bank dut (
        .clk(clk), .rst(rst), .ena_wr(ena_wr), .ctrl_wr(ctrl_wr),
        .load_wr(load_wr), .wr_data(wr_data), .frame_tick(frame_tick),
        .mute(mute), .active(active), .restart(restart)
    );

    function automatic int exp_len(input int idx);
        int k;
        int base;
        if (idx % 2 == 1) return (idx == 1) ? 254 : idx - 1;
        k    = (idx / 2) % 8;
        base = (idx >= 16) ? 12 : 10;
        if (k < 5)  return base << k;
        if (k == 5) return base * 6;
        if (k == 6) return (idx >= 16) ? 16 : 14;
        return (idx >= 16) ? 32 : 26;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ena_wr = 0; ctrl_wr = 0; load_wr = 0; frame_tick = 0; wr_data = 0;
    endtask

    task automatic set_en(input logic [7:0] d);
        ena_wr = 1; wr_data = d; cyc(); idle();
    endtask

    task automatic load(input int ch, input int idx);
        load_wr[ch] = 1'b1; wr_data = 8'(idx << 3) | 8'h05; cyc(); idle();
    endtask

    task automatic ctrl(input int ch, input logic [7:0] d);
        ctrl_wr[ch] = 1'b1; wr_data = d; cyc(); idle();
    endtask

    task automatic ticks(input int n);
        for (int t = 0; t < n; t++) begin
            frame_tick = 1; cyc();
        end
        frame_tick = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        cyc(); cyc();
        rst = 0;
        // R9 reset state
        chk("R9 mute after reset", int'(mute), 'hF);
        chk("R9 active after reset", int'(active), 0);
        chk("R9 restart after reset", int'(restart), 0);

        // R2 load while disabled ignored; R7 restart still pulses
        load_wr[0] = 1; wr_data = 8'(3 << 3); cyc(); idle();
        chk("R2 disabled load ignored", int'(active), 0);
        chk("R7 restart when disabled", int'(restart), 'h1);
        cyc();
        chk("R7 restart one cycle", int'(restart), 0);

        // R5/R8 enabling alone has no effect; upper bits ignored
        set_en(8'hFF);
        chk("R5 enable no immediate effect", int'(active), 0);

        // R1 R3 R6 R7 R8 sweep of every index on every channel
        for (int ch = 0; ch < 4; ch++) begin
            for (int idx = 0; idx < 32; idx++) begin
                int n;
                n = exp_len(idx);
                load(ch, idx);
                chk("R1 load makes active", int'(active), 1 << ch);
                chk("R7 restart after load", int'(restart), 1 << ch);
                ticks(n - 1);
                chk("R3 active before last strobe", int'(active), 1 << ch);
                ticks(1);
                chk("R3 silent after N strobes", int'(active), 0);
                chk("R6 mute when zero", int'(mute), 'hF);
                ticks(2);
                chk("R3 zero stays zero", int'(active), 0);
            end
        end

        // R5 clearing the enable destroys the count
        load(1, 1);
        chk("R5 loaded", int'(active), 'h2);
        set_en(8'h0D);
        chk("R5 cleared by disable", int'(active), 0);
        set_en(8'h0F);
        chk("R5 count not restored", int'(active), 0);
        load(1, 5);
        chk("R8 only channel 1", int'(active), 'h2);
        chk("R6 mute inverse", int'(mute), 'hD);
        set_en(8'hFD);
        chk("R8 bit1 clears channel 1", int'(active), 0);
        set_en(8'h0F);

        // R4 halt on pulse channel (bit 5)
        ctrl(0, 8'h20);
        load(0, 0);
        ticks(30);
        chk("R4 halted pulse keeps count", int'(active), 'h1);
        ctrl(0, 8'h00);
        ticks(9);
        chk("R4 resumes after unhalt", int'(active), 'h1);
        ticks(1);
        chk("R4 reaches zero after unhalt", int'(active), 0);
        ctrl(0, 8'h80);
        load(0, 3);
        ticks(2);
        chk("R4 bit7 does not halt pulse", int'(active), 0);

        // R4 triangle halt uses bit 7
        ctrl(2, 8'h20);
        load(2, 3);
        ticks(2);
        chk("R4 bit5 does not halt triangle", int'(active), 0);
        ctrl(2, 8'h80);
        load(2, 3);
        ticks(5);
        chk("R4 bit7 halts triangle", int'(active), 'h4);
        ctrl(2, 8'h00);
        ticks(2);
        chk("R4 triangle unhalted", int'(active), 0);

        // R4 noise halt uses bit 5
        ctrl(3, 8'h20);
        load(3, 3);
        ticks(4);
        chk("R4 bit5 halts noise", int'(active), 'h8);
        ctrl(3, 8'h00);
        ticks(2);
        chk("R4 noise unhalted", int'(active), 0);

        // R10 load and strobe in the same cycle
        load_wr[0] = 1; wr_data = 8'(3 << 3); frame_tick = 1; cyc(); idle();
        ticks(1);
        chk("R10 load wins over strobe", int'(active), 'h1);
        ticks(1);
        chk("R10 then counts down", int'(active), 0);

        // R11 enable write and load in the same cycle
        ena_wr = 1; load_wr[1] = 1; wr_data = 8'(1 << 3) | 8'h05; cyc(); idle();
        chk("R11 load with clearing enable rejected", int'(active), 0);
        ena_wr = 1; load_wr[1] = 1; wr_data = 8'(1 << 3) | 8'h02; cyc(); idle();
        chk("R11 load with setting enable accepted", int'(active), 'h2);
        set_en(8'h00);
        chk("R5 final disable", int'(active), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule